// File: doc/BRIEF.md
# Phase-to-Duty Detector

This block measures how far a measured square wave lags a reference square wave and turns that lag into a pulse-width output. Both inputs are already squared digital signals. They are brought into the sample-clock domain, and each rising edge is reduced to a strobe one sample clock wide. A reference strobe drives the output low. A measured-signal strobe drives it high again. Over one period, the fraction of time the output spends low equals the lag divided by the period. A later low-pass stage, or the on-block counter, converts that fraction into a phase value.

Lags close to zero are unreliable in practice, because the two strobes crowd each other. A control input complements the reference before edge detection. This shifts the measurement by half a period, and the consumer subtracts that offset afterwards. A counter-based accumulator counts the output-high sample clocks and the total sample clocks between consecutive reference strobes. It reports both counts once per reference period with a one-cycle valid pulse, and it raises a sticky timeout flag when the period counter saturates before a reference strobe arrives.

Top module: `phase_duty_detector`

## Requirements
- R1: After a rising edge of the effective reference, `phase_out` goes low on the third rising clock edge, counted from the first edge that samples the new input level, and stays low until a measured-signal strobe arrives.
- R2: A rising edge of `meas_in` drives `phase_out` high with the same three-edge latency, and `phase_out` stays high until the next reference strobe.
- R3: Only rising edges act. A level held high, a falling edge of `meas_in`, and an input already high when reset is released all leave `phase_out` unchanged. Each strobe lasts exactly one clock.
- R4: When a reference strobe and a measured-signal strobe occur in the same clock, `phase_out` is 1.
- R5: With reference edges only and no measured-signal edges, `phase_out` stays 0 indefinitely.
- R6: With `ref_invert` = 1 the effective reference is the complement of `ref_in`, so falling edges of `ref_in` drive `phase_out` low.
- R7: For a reference period of P clocks and a measured lag of L clocks (0 <= L < P, measured from the effective reference edge), each report has `period_count` = P and `high_count` = P - L. Each report is marked by `meas_valid` high for one clock, starting with the same edge on which `phase_out` falls.
- R8: Reset sets `phase_out` = 1, `meas_valid` = 0 and `timeout` = 0, and clears the counters. The first reference strobe after reset produces no report. The second reference strobe does.
- R9: If the period counter reaches 2^CNT_W - 1 without a reference strobe, `timeout` goes to 1 and stays there. The next reference strobe clears `timeout`, produces no report, and restarts normal reporting from the following period.
- R10: A reported `high_count` never exceeds the reported `period_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, must be released synchronously |
| ref_in | input | 1 | Squared reference signal, asynchronous to `clk` |
| meas_in | input | 1 | Squared measured signal, asynchronous to `clk` |
| ref_invert | input | 1 | 1 selects the complemented reference |
| phase_out | output | 1 | Pulse-width output: low from a reference edge until a measured edge |
| high_count | output | CNT_W | Output-high clocks in the last reported period |
| period_count | output | CNT_W | Clocks in the last reported period |
| meas_valid | output | 1 | One-clock pulse when new counts are reported |
| timeout | output | 1 | Period counter saturated without a reference strobe |

## Verification
Wrong internal state shows up at the ports within one reference period:
- A lost or doubled strobe changes the level of `phase_out` three clocks after the input edge.
- A strobe that is not gated during start-up drives `phase_out` low right after reset.
- An off-by-one in the accumulator window shifts `high_count` or `period_count` by one in the next report.
- A wrong priority on coincident strobes turns the zero-lag case into a report with `high_count` = 0 instead of P.

Timeout errors appear as a flag that rises too early or too late after the last strobe, or as a report that is not suppressed on the strobe that follows a timeout.

// File: rtl/pdd_pkg.sv
package pdd_pkg;

  // Bit positions of the synchronized control/data vector.
  localparam int unsigned SY_REF = 0;
  localparam int unsigned SY_MEAS = 1;
  localparam int unsigned SY_INV = 2;
  localparam int unsigned SY_W = 3;

  // Pair of one-clock event strobes feeding the output flop.
  typedef struct packed {
    logic set_low;   // reference event
    logic set_high;  // measured-signal event
  } pdd_strobe_t;

endpackage

// File: rtl/pdd_sync.sv
module pdd_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             ready
);

  localparam int unsigned FILL_W = STAGES + 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_d;

  // Shift chain next state
  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
    fill_d = {fill_q[FILL_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= '0;
      end
      fill_q <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= stage_d[i];
      end
      fill_q <= fill_d;
    end
  end

  assign q = stage_q[STAGES-1];
  // One cycle beyond the chain depth, so the edge history holds a real level.
  assign ready = fill_q[FILL_W-1];

endmodule

// File: rtl/pdd_edge.sv
module pdd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic enable,
  output logic strobe
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level;
  end

  // History resets high: a level that is already high gives no event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign strobe = enable & level & ~prev_q;

endmodule

// File: rtl/pdd_phase_core.sv
module pdd_phase_core
  import pdd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pdd_strobe_t stb,
  output logic        phase_q
);

  logic phase_d;

  // The measured-signal event has priority over the reference event.
  always_comb begin
    phase_d = phase_q;
    if (stb.set_high) begin
      phase_d = 1'b1;
    end else if (stb.set_low) begin
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/pdd_duty_acc.sv
module pdd_duty_acc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_stb,
  input  logic             level,
  output logic [CNT_W-1:0] high_count,
  output logic [CNT_W-1:0] period_count,
  output logic             valid,
  output logic             timeout
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] hrep_q, hrep_d;
  logic [CNT_W-1:0] prep_q, prep_d;
  logic             armed_q, armed_d;
  logic             vld_q, vld_d;
  logic             to_q, to_d;
  logic             per_full;
  logic             hi_full;
  logic             rep_en;

  always_comb begin
    per_full = (per_q == CNT_MAX);
    hi_full  = (hi_q == CNT_MAX);
    // A report needs an earlier strobe and a window that never saturated.
    rep_en   = period_stb & armed_q & ~to_q & ~per_full;

    hi_d    = hi_q;
    per_d   = per_q;
    hrep_d  = hrep_q;
    prep_d  = prep_q;
    armed_d = armed_q;
    to_d    = to_q;
    vld_d   = rep_en;

    if (period_stb) begin
      hi_d    = '0;
      per_d   = '0;
      armed_d = 1'b1;
      to_d    = 1'b0;
    end else begin
      if (per_full) begin
        to_d = 1'b1;
      end else begin
        per_d = per_q + CNT_ONE;
      end
      if (level && !hi_full) begin
        hi_d = hi_q + CNT_ONE;
      end
    end

    if (rep_en) begin
      hrep_d = level ? (hi_q + CNT_ONE) : hi_q;
      prep_d = per_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      per_q   <= '0;
      hrep_q  <= '0;
      prep_q  <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      hi_q    <= hi_d;
      per_q   <= per_d;
      hrep_q  <= hrep_d;
      prep_q  <= prep_d;
      armed_q <= armed_d;
      vld_q   <= vld_d;
      to_q    <= to_d;
    end
  end

  assign high_count   = hrep_q;
  assign period_count = prep_q;
  assign valid        = vld_q;
  assign timeout      = to_q;

endmodule

// File: rtl/phase_duty_detector.sv
module phase_duty_detector
  import pdd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             meas_in,
  input  logic             ref_invert,
  output logic             phase_out,
  output logic [CNT_W-1:0] high_count,
  output logic [CNT_W-1:0] period_count,
  output logic             meas_valid,
  output logic             timeout
);

  logic [SY_W-1:0] raw_vec;
  logic [SY_W-1:0] sy_vec;
  logic            sy_ready;
  logic            ref_eff;
  logic            ref_stb;
  logic            clr_stb;
  pdd_strobe_t     stb;

  assign raw_vec[SY_REF]  = ref_in;
  assign raw_vec[SY_MEAS] = meas_in;
  assign raw_vec[SY_INV]  = ref_invert;

  pdd_sync #(.WIDTH(SY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_vec),
    .q     (sy_vec),
    .ready (sy_ready)
  );

  assign ref_eff = sy_vec[SY_REF] ^ sy_vec[SY_INV];

  pdd_edge u_ref_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (ref_eff),
    .enable (sy_ready),
    .strobe (ref_stb)
  );

  pdd_edge u_meas_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (sy_vec[SY_MEAS]),
    .enable (sy_ready),
    .strobe (clr_stb)
  );

  assign stb.set_low  = ref_stb;
  assign stb.set_high = clr_stb;

  pdd_phase_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .phase_q (phase_out)
  );

  pdd_duty_acc #(.CNT_W(CNT_W)) u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_stb   (ref_stb),
    .level        (phase_out),
    .high_count   (high_count),
    .period_count (period_count),
    .valid        (meas_valid),
    .timeout      (timeout)
  );

endmodule

// File: rtl/phase_duty_detector_chk.sv
module phase_duty_detector_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_stb,
  input logic             clr_stb,
  input logic             phase_out,
  input logic             meas_valid,
  input logic [CNT_W-1:0] high_count,
  input logic [CNT_W-1:0] period_count,
  input logic             timeout
);

  AST_REF_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb && !clr_stb) |=> !phase_out); // R1
  AST_MEAS_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> phase_out); // R2
  AST_COINCIDENT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && ref_stb) |=> phase_out); // R4
  AST_OUTPUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_stb && !clr_stb) |=> $stable(phase_out)); // R5
  AST_REF_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> !ref_stb); // R3
  AST_MEAS_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> !clr_stb); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid); // R7
  AST_HIGH_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (high_count <= period_count)); // R10
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !ref_stb) |=> timeout); // R9
  AST_TIMEOUT_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && ref_stb) |=> (!meas_valid && !timeout)); // R9

endmodule

bind phase_duty_detector phase_duty_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_stb      (ref_stb),
  .clr_stb      (clr_stb),
  .phase_out    (phase_out),
  .meas_valid   (meas_valid),
  .high_count   (high_count),
  .period_count (period_count),
  .timeout      (timeout)
);

// File: tb/phase_duty_detector_tb.sv
module phase_duty_detector_tb;

  localparam int CW = 8;
  localparam int NV = 8;
  // Period, lag (clocks after ref_in rise), invert
  localparam int VEC_P [NV] = '{36, 36, 36, 40, 36, 20, 24, 30};
  localparam int VEC_L [NV] = '{ 9, 18, 27, 10,  2,  1, 23, 15};
  localparam int VEC_I [NV] = '{ 0,  0,  0,  1,  1,  0,  0,  1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ref_in;
  logic          meas_in;
  logic          ref_invert;
  logic          phase_out;
  logic [CW-1:0] high_count;
  logic [CW-1:0] period_count;
  logic          meas_valid;
  logic          timeout;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  phase_duty_detector #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_in       (ref_in),
    .meas_in      (meas_in),
    .ref_invert   (ref_invert),
    .phase_out    (phase_out),
    .high_count   (high_count),
    .period_count (period_count),
    .meas_valid   (meas_valid),
    .timeout      (timeout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit inv, input bit ref_lvl);
    rst_n = 1'b0;
    ref_in = ref_lvl;
    meas_in = 1'b0;
    ref_invert = inv;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nrep;
    int highs;
    bit seen;
    @(negedge clk);

    // R8: reset state
    do_reset(1'b0, 1'b0);
    check(phase_out == 1'b1, "R8", "phase_out after reset", phase_out, 1);
    check(meas_valid == 1'b0, "R8", "meas_valid after reset", meas_valid, 0);
    check(timeout == 1'b0, "R8", "timeout after reset", timeout, 0);

    // Vector table: duty reports per period/lag/invert
    for (int v = 0; v < NV; v++) begin
      int p, l, lag, exp_hi;
      p = VEC_P[v];
      l = VEC_L[v];
      lag = (VEC_I[v] != 0) ? ((l + p - p / 2) % p) : l;
      exp_hi = p - lag;
      do_reset(VEC_I[v] != 0, 1'b0);
      nrep = 0;
      for (int c = 0; c < 5 * p; c++) begin
        ref_in = ((c % p) < p / 2);
        meas_in = (c >= l) && (((c - l) % p) < p / 2);
        step();
        if (meas_valid) begin
          nrep++;
          check(int'(high_count) == exp_hi, "R7", $sformatf("vec%0d high_count", v),
                high_count, exp_hi);
          check(int'(period_count) == p, "R7", $sformatf("vec%0d period_count", v),
                period_count, p);
          check(high_count <= period_count, "R10", "high not above period",
                high_count, period_count);
        end
      end
      check(nrep >= 3, "R7", $sformatf("vec%0d report count", v), nrep, 3);
      ref_in = 1'b0;
      meas_in = 1'b0;
    end

    // R1 / R2: three-edge latency
    do_reset(1'b0, 1'b0);
    ref_in = 1'b1;
    step(); step();
    check(phase_out == 1'b1, "R1", "phase_out after two edges", phase_out, 1);
    step();
    check(phase_out == 1'b0, "R1", "phase_out after three edges", phase_out, 0);
    meas_in = 1'b1;
    step(); step();
    check(phase_out == 1'b0, "R2", "phase_out after two edges", phase_out, 0);
    step();
    check(phase_out == 1'b1, "R2", "phase_out after three edges", phase_out, 1);

    // R3: levels held high and falling edges do nothing
    highs = 0;
    for (int c = 0; c < 20; c++) begin
      step();
      if (phase_out) highs++;
    end
    check(highs == 20, "R3", "held-high inputs keep output", highs, 20);
    meas_in = 1'b0;
    repeat (5) step();
    check(phase_out == 1'b1, "R3", "meas falling edge ignored", phase_out, 1);

    // R4: coincident edges, clear wins
    ref_in = 1'b0;
    repeat (4) step();
    ref_in = 1'b1;
    repeat (4) step();
    check(phase_out == 1'b0, "R4", "setup low", phase_out, 0);
    ref_in = 1'b0;
    repeat (4) step();
    ref_in = 1'b1;
    meas_in = 1'b1;
    repeat (4) step();
    check(phase_out == 1'b1, "R4", "coincident strobes", phase_out, 1);

    // R3: input already high at reset release
    do_reset(1'b0, 1'b1);
    repeat (10) step();
    check(phase_out == 1'b1, "R3", "ref high through reset", phase_out, 1);
    do_reset(1'b1, 1'b0);
    repeat (10) step();
    check(phase_out == 1'b1, "R3", "inverted ref high through reset", phase_out, 1);

    // R6: inverted reference acts on falling ref_in edges
    do_reset(1'b1, 1'b1);
    ref_in = 1'b0;
    repeat (3) step();
    check(phase_out == 1'b0, "R6", "falling ref_in drives low", phase_out, 0);
    meas_in = 1'b1;
    repeat (3) step();
    ref_in = 1'b1;
    repeat (4) step();
    check(phase_out == 1'b1, "R6", "rising ref_in ignored when inverted", phase_out, 1);

    // R5: reference only
    do_reset(1'b0, 1'b0);
    highs = 0;
    for (int c = 0; c < 60; c++) begin
      ref_in = ((c % 10) < 5);
      step();
      if (c >= 2 && phase_out) highs++;
    end
    check(highs == 0, "R5", "high cycles with ref only", highs, 0);

    // R8: first strobe does not report; second does
    do_reset(1'b0, 1'b0);
    seen = 1'b0;
    for (int c = 0; c < 20; c++) begin
      ref_in = (c < 5);
      step();
      if (meas_valid) seen = 1'b1;
    end
    check(seen == 1'b0, "R8", "report after first strobe", seen, 0);
    ref_in = 1'b1;
    step(); step();
    check(meas_valid == 1'b0, "R8", "valid before latency", meas_valid, 0);
    step();
    check(meas_valid == 1'b1, "R8", "valid on second strobe", meas_valid, 1);
    check(int'(period_count) == 20, "R8", "period of first report", period_count, 20);
    check(int'(high_count) == 0, "R8", "high of first report", high_count, 0);
    step();
    check(meas_valid == 1'b0, "R7", "valid lasts one clock", meas_valid, 0);

    // R9: timeout
    ref_in = 1'b0;
    repeat (100) step();
    check(timeout == 1'b0, "R9", "timeout early", timeout, 0);
    repeat (170) step();
    check(timeout == 1'b1, "R9", "timeout after saturation", timeout, 1);
    ref_in = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 6; c++) begin
      step();
      if (meas_valid) seen = 1'b1;
    end
    check(seen == 1'b0, "R9", "no report on strobe after timeout", seen, 0);
    check(timeout == 1'b0, "R9", "timeout cleared by strobe", timeout, 0);
    // Next period of 20 clocks reports normally again (strobe 3 clocks behind ref_in)
    seen = 1'b0;
    for (int c = 0; c < 14; c++) begin
      ref_in = (c < 5);
      step();
    end
    ref_in = 1'b1;
    for (int c = 0; c < 4; c++) begin
      step();
      if (meas_valid) begin
        seen = 1'b1;
        check(int'(period_count) == 20, "R9", "period after recovery", period_count, 20);
      end
    end
    check(seen == 1'b1, "R9", "report resumes after timeout", seen, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule